// File: doc/BRIEF.md
# Indexed Register Window for an Interrupt Routing Table

This block is the software-facing register front end of an interrupt routing controller. A bus master sees only two locations: an 8-bit index register and a 32-bit data window. The index value chooses which internal register the window opens onto. The window can reach a 4-bit controller identifier, a read-only version word, and a routing table that holds one 64-bit entry per interrupt input. Each entry is accessed as two 32-bit halves.

Every entry field is exported in parallel so that the delivery logic can use it. These fields are vector, delivery mode, destination mode, trigger mode, mask, destination and the remote-acknowledge flag. The block also sends the delivery logic two one-cycle event pulses: one when software changes an entry's mask bit, and one when a table write leaves a level-triggered entry with its request line high, so that the entry must be serviced again. Delivering the interrupt itself is done elsewhere.

Top module: `irq_route_regs`

## Requirements
- R1: Only the low 8 bits of `bus_addr` are decoded. Offset 0x00 is the index register and offset 0x10 is the data window. A read of any other offset returns zero, and a write to any other offset changes nothing.
- R2: The index register is 8 bits wide. A write to it keeps bits 7:0 of the extended write data, and a read returns that value.
- R3: Write data is extended according to `bus_size`: 0 keeps bits 7:0, 1 keeps bits 15:0, and 2 or 3 keep bits 31:0. The dropped upper bits become zero.
- R4: Index 0x00 returns the controller ID in bits 27:24 with zeros elsewhere, and a write there loads the ID from bits 27:24. Index 0x02 returns the same word, but writes to it are ignored.
- R5: Index 0x01 returns (pin count − 1) in bits 23:16 and the `VERSION` parameter in bits 7:0, with zeros elsewhere. Writes to it are ignored.
- R6: For an index of 0x10 or above, the entry number is (index − 0x10)/2. An even index reaches entry bits 31:0 and an odd index reaches bits 63:32. The fields are vector 7:0, delivery mode 10:8, destination mode 11, remote-acknowledge 14, trigger 15 (1 = level) and mask 16, with destination in 63:56.
- R7: An index whose entry number is at or beyond the pin count, or an index from 0x03 to 0x0F, reads as all ones. A write through such an index changes no state and raises no event.
- R8: Bit 14 cannot be written. A pulse on `rirr_set[p]` sets it, and a write to the low half of entry p clears it. A write to the high half leaves it unchanged.
- R9: When a write to a low half changes the entry's mask bit, `mask_evt` is high for exactly the cycle after the write edge, with the pin number and the new mask value. A write that leaves the mask unchanged raises no pulse.
- R10: After any write to either half of an entry, if the entry is level-triggered and its registered `pin_level` bit is 1, `svc_evt` is high for the next cycle with that pin number. An edge-triggered entry raises no pulse.
- R11: After reset, the index register and the ID are zero, every entry reads 0x00010000 in its low half and 0 in its high half (masked, all other fields zero), and the request register is clear.
- R12: A read strobe captures the selected value into `bus_rdata` at the clock edge. `bus_rdata` keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_level | input | NUM_PINS | Request line per input pin, registered internally |
| rirr_set | input | NUM_PINS | Sets the remote-acknowledge flag of a pin |
| tbl_vector | output | 8*NUM_PINS | Vector field per entry |
| tbl_dmode | output | 3*NUM_PINS | Delivery mode per entry |
| tbl_destmode | output | NUM_PINS | Destination mode per entry |
| tbl_level | output | NUM_PINS | Trigger mode per entry (1 = level) |
| tbl_mask | output | NUM_PINS | Mask bit per entry |
| tbl_dest | output | 8*NUM_PINS | Destination per entry |
| tbl_rirr | output | NUM_PINS | Remote-acknowledge flag per entry |
| mask_evt | output | 1 | Mask-change pulse |
| mask_evt_pin | output | PIN_W | Pin whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| svc_evt | output | 1 | Re-service pulse |
| svc_evt_pin | output | PIN_W | Pin to re-service |

## Verification
A single write to the low half of a level-triggered entry can unmask it while its request line is high. That one write then raises both the mask-change pulse and the re-service pulse, and both must appear on the same cycle with the same pin number. The bench sets up this case by holding the request line of pin 7 high. It first writes a masked level entry, which must produce a re-service pulse and no mask pulse. It then rewrites the entry unmasked and checks that both pulses are present together with matching pin numbers and the new mask value.

// File: rtl/irw_pkg.sv
package irw_pkg;
   localparam int unsigned IDX_W       = 8;
   localparam logic [7:0]  OFS_INDEX   = 8'h00;
   localparam logic [7:0]  OFS_WINDOW  = 8'h10;
   localparam logic [7:0]  SEL_ID      = 8'h00;
   localparam logic [7:0]  SEL_VER     = 8'h01;
   localparam logic [7:0]  SEL_ARB     = 8'h02;
   localparam logic [7:0]  SEL_TBL     = 8'h10;

   localparam int unsigned B_VEC   = 0;
   localparam int unsigned B_DMODE = 8;
   localparam int unsigned B_DSTM  = 11;
   localparam int unsigned B_RIRR  = 14;
   localparam int unsigned B_TRIG  = 15;
   localparam int unsigned B_MASK  = 16;
   localparam int unsigned B_DEST  = 56;

   localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } xfer_size_e;

   function automatic logic [31:0] extend_wdata(input xfer_size_e sz, input logic [31:0] d);
      case (sz)
         SZ_BYTE: extend_wdata = {24'h0, d[7:0]};
         SZ_HALF: extend_wdata = {16'h0, d[15:0]};
         default: extend_wdata = d;
      endcase
   endfunction
endpackage

// File: rtl/irw_decode.sv
module irw_decode
   import irw_pkg::*;
#(
   parameter int unsigned NUM_PINS = 24,
   parameter int unsigned PIN_W    = 5
) (
   input  logic [7:0]       ofs,
   input  logic [7:0]       idx,
   input  logic [1:0]       size,
   input  logic [31:0]      wdata,
   output logic             at_index,
   output logic             at_window,
   output logic             sel_id,
   output logic             sel_ver,
   output logic             sel_arb,
   output logic             sel_tbl,
   output logic             tbl_hi,
   output logic [PIN_W-1:0] tbl_pin,
   output logic [31:0]      wdata_ext
);
   localparam logic [6:0] NP7 = 7'(NUM_PINS);

   logic [6:0] ent_num;
   logic [7:0] rel_idx;

   assign rel_idx   = idx - SEL_TBL;
   assign ent_num   = rel_idx[7:1];
   assign at_index  = (ofs == OFS_INDEX);
   assign at_window = (ofs == OFS_WINDOW);
   assign sel_id    = (idx == SEL_ID);
   assign sel_ver   = (idx == SEL_VER);
   assign sel_arb   = (idx == SEL_ARB);
   assign sel_tbl   = (idx >= SEL_TBL) && (ent_num < NP7);
   assign tbl_hi    = idx[0];
   assign tbl_pin   = ent_num[PIN_W-1:0];
   assign wdata_ext = extend_wdata(xfer_size_e'(size), wdata);
endmodule

// File: rtl/irw_entry.sv
module irw_entry
   import irw_pkg::*;
#(
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   input  logic        rirr_set,
   output logic [63:0] ent_q
);
   logic rirr_nxt;

   generate
      if (CLEAR_WINS) begin : g_clear_first
         assign rirr_nxt = wr_lo ? 1'b0 : (rirr_set | ent_q[B_RIRR]);
      end else begin : g_set_first
         assign rirr_nxt = rirr_set ? 1'b1 : (ent_q[B_RIRR] & ~wr_lo);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_q <= ENTRY_RST;
      end else begin
         if (wr_lo) ent_q[31:0]  <= wdata;
         if (wr_hi) ent_q[63:32] <= wdata;
         ent_q[B_RIRR] <= rirr_nxt;
      end
   end

   assert_rirr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && CLEAR_WINS) |=> !ent_q[B_RIRR]);
   assert_entry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_lo || wr_hi) |=> ($stable(ent_q[63:32]) && $stable(ent_q[13:0]) && $stable(ent_q[31:15])));
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irw_pkg::*;
#(
   parameter int unsigned NUM_PINS   = 24,
   parameter int unsigned ADDR_W     = 32,
   parameter logic [7:0]  VERSION    = 8'h11,
   parameter bit          CLEAR_WINS = 1'b1,
   localparam int unsigned PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [1:0]            bus_size,
   input  logic [31:0]           bus_wdata,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_level,
   input  logic [NUM_PINS-1:0]   rirr_set,
   output logic [8*NUM_PINS-1:0] tbl_vector,
   output logic [3*NUM_PINS-1:0] tbl_dmode,
   output logic [NUM_PINS-1:0]   tbl_destmode,
   output logic [NUM_PINS-1:0]   tbl_level,
   output logic [NUM_PINS-1:0]   tbl_mask,
   output logic [8*NUM_PINS-1:0] tbl_dest,
   output logic [NUM_PINS-1:0]   tbl_rirr,
   output logic                  mask_evt,
   output logic [PIN_W-1:0]      mask_evt_pin,
   output logic                  mask_evt_val,
   output logic                  svc_evt,
   output logic [PIN_W-1:0]      svc_evt_pin
);
   localparam logic [7:0] PIN_MAX = 8'(NUM_PINS - 1);

   generate
      if (NUM_PINS < 1 || NUM_PINS > 120) begin : g_bad_pins
         $error("NUM_PINS must lie in 1..120");
      end
      if (ADDR_W < 9) begin : g_bad_addr
         $error("ADDR_W must exceed 8");
      end
   endgenerate

   logic [7:0]       idx_q;
   logic [3:0]       id_q;
   logic [NUM_PINS-1:0] req_q;
   logic [63:0]      ent_arr [NUM_PINS];

   logic             at_index, at_window, sel_id, sel_ver, sel_arb, sel_tbl, tbl_hi;
   logic [PIN_W-1:0] tbl_pin;
   logic [31:0]      wdata_ext;
   logic             unused_addr;

   assign unused_addr = ^bus_addr[ADDR_W-1:8];

   irw_decode #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_dec (
      .ofs       (bus_addr[7:0]),
      .idx       (idx_q),
      .size      (bus_size),
      .wdata     (bus_wdata),
      .at_index  (at_index),
      .at_window (at_window),
      .sel_id    (sel_id),
      .sel_ver   (sel_ver),
      .sel_arb   (sel_arb),
      .sel_tbl   (sel_tbl),
      .tbl_hi    (tbl_hi),
      .tbl_pin   (tbl_pin),
      .wdata_ext (wdata_ext)
   );

   logic win_wr, tbl_wr, wr_lo_any;
   assign win_wr    = bus_wr && at_window;
   assign tbl_wr    = win_wr && sel_tbl;
   assign wr_lo_any = tbl_wr && !tbl_hi;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
         logic hit;
         assign hit = tbl_wr && (tbl_pin == PIN_W'(gi));
         irw_entry #(.CLEAR_WINS(CLEAR_WINS)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (hit && !tbl_hi),
            .wr_hi    (hit && tbl_hi),
            .wdata    (wdata_ext),
            .rirr_set (rirr_set[gi]),
            .ent_q    (ent_arr[gi])
         );
         assign tbl_vector[8*gi +: 8]  = ent_arr[gi][B_VEC +: 8];
         assign tbl_dmode[3*gi +: 3]   = ent_arr[gi][B_DMODE +: 3];
         assign tbl_destmode[gi]       = ent_arr[gi][B_DSTM];
         assign tbl_level[gi]          = ent_arr[gi][B_TRIG];
         assign tbl_mask[gi]           = ent_arr[gi][B_MASK];
         assign tbl_dest[8*gi +: 8]    = ent_arr[gi][B_DEST +: 8];
         assign tbl_rirr[gi]           = ent_arr[gi][B_RIRR];
      end
   endgenerate

   logic [63:0] cur_ent;
   logic        new_trig, mask_chg, svc_now;
   assign cur_ent  = ent_arr[tbl_pin];
   assign new_trig = wr_lo_any ? wdata_ext[B_TRIG] : cur_ent[B_TRIG];
   assign mask_chg = wr_lo_any && (wdata_ext[B_MASK] != cur_ent[B_MASK]);
   assign svc_now  = tbl_wr && new_trig && req_q[tbl_pin];

   logic [31:0] win_val;
   always_comb begin
      win_val = '1;
      if (sel_id || sel_arb)  win_val = {4'h0, id_q, 24'h0};
      else if (sel_ver)       win_val = {8'h0, PIN_MAX, 8'h0, VERSION};
      else if (sel_tbl)       win_val = tbl_hi ? cur_ent[63:32] : cur_ent[31:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q        <= '0;
         id_q         <= '0;
         req_q        <= '0;
         bus_rdata    <= '0;
         mask_evt     <= 1'b0;
         mask_evt_pin <= '0;
         mask_evt_val <= 1'b0;
         svc_evt      <= 1'b0;
         svc_evt_pin  <= '0;
      end else begin
         req_q    <= pin_level;
         mask_evt <= mask_chg;
         svc_evt  <= svc_now;
         if (mask_chg) begin
            mask_evt_pin <= tbl_pin;
            mask_evt_val <= wdata_ext[B_MASK];
         end
         if (svc_now) svc_evt_pin <= tbl_pin;
         if (bus_wr && at_index) idx_q <= wdata_ext[7:0];
         if (win_wr && sel_id)   id_q  <= wdata_ext[27:24];
         if (bus_rd) begin
            if (at_index)       bus_rdata <= {24'h0, idx_q};
            else if (at_window) bus_rdata <= win_val;
            else                bus_rdata <= '0;
         end
      end
   end

   assert_mask_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mask_evt |-> (ent_arr[mask_evt_pin][B_MASK] == mask_evt_val));
   assert_svc_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      svc_evt |-> ent_arr[svc_evt_pin][B_TRIG]);
   assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && at_index) |=> $stable(idx_q));
   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
   assert_oor_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && !sel_tbl) |=> (!mask_evt && !svc_evt));
endmodule

// File: tb/irq_route_regs_bench.sv
module irq_route_regs_bench;
   localparam int NP = 24;
   localparam int PW = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic            rst_n;
   logic [31:0]     bus_addr;
   logic [1:0]      bus_size;
   logic [31:0]     bus_wdata;
   logic            bus_wr, bus_rd;
   logic [31:0]     bus_rdata;
   logic [NP-1:0]   pin_level, rirr_set;
   logic [8*NP-1:0] tbl_vector, tbl_dest;
   logic [3*NP-1:0] tbl_dmode;
   logic [NP-1:0]   tbl_destmode, tbl_level, tbl_mask, tbl_rirr;
   logic            mask_evt, mask_evt_val, svc_evt;
   logic [PW-1:0]   mask_evt_pin, svc_evt_pin;

   irq_route_regs #(.NUM_PINS(NP)) u_irq_route_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pin_level(pin_level), .rirr_set(rirr_set), .tbl_vector(tbl_vector),
      .tbl_dmode(tbl_dmode), .tbl_destmode(tbl_destmode), .tbl_level(tbl_level),
      .tbl_mask(tbl_mask), .tbl_dest(tbl_dest), .tbl_rirr(tbl_rirr),
      .mask_evt(mask_evt), .mask_evt_pin(mask_evt_pin), .mask_evt_val(mask_evt_val),
      .svc_evt(svc_evt), .svc_evt_pin(svc_evt_pin)
   );

   int checks = 0;
   int fails  = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic bwrite(input logic [31:0] addr, input logic [31:0] d, input logic [1:0] sz);
      @(negedge clk);
      bus_addr = addr; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic select(input logic [7:0] idx);
      bwrite(32'h0, {24'h0, idx}, 2'd2);
   endtask

   task automatic bread(input logic [31:0] addr, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_addr = addr; bus_rd = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // scoreboard monitor: one expected word per captured read
   initial begin
      forever begin
         @(posedge clk);
         if (bus_rd === 1'b1) begin
            @(negedge clk);
            if (exp_q.size() == 0) check("scoreboard", 64'h1, 64'h0);
            else check(tag_q.pop_front(), {32'h0, bus_rdata}, {32'h0, exp_q.pop_front()});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; bus_addr = '0; bus_size = 2'd2; bus_wdata = '0;
      bus_wr = 1'b0; bus_rd = 1'b0; pin_level = '0; rirr_set = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      check("R11 mask", {40'h0, tbl_mask}, {40'h0, {NP{1'b1}}});
      bread(32'h0, 32'h0, "R11 index");
      bread(32'h10, 32'h0, "R11 id");
      select(8'h10);
      bread(32'h10, 32'h0001_0000, "R11 entry lo");
      select(8'h11);
      bread(32'h10, 32'h0, "R11 entry hi");

      // R2 index keeps 8 bits
      bwrite(32'h0, 32'h0000_01FF, 2'd2);
      bread(32'h0, 32'h0000_00FF, "R2 index");

      // R1 other offsets, address aliasing
      bwrite(32'h4, 32'h0000_0033, 2'd2);
      bread(32'h0, 32'h0000_00FF, "R1 write ignored");
      bread(32'h20, 32'h0, "R1 other offset");
      bread(32'hFEDC_BA00, 32'h0000_00FF, "R1 alias");

      // R4 / R3 id and size extension
      select(8'h00);
      bwrite(32'h10, 32'h0A00_0000, 2'd2);
      bread(32'h10, 32'h0A00_0000, "R4 id");
      select(8'h02);
      bwrite(32'h10, 32'h0300_0000, 2'd2);
      bread(32'h10, 32'h0A00_0000, "R4 arb");
      select(8'h00);
      bwrite(32'h10, 32'h0500_0000, 2'd1);
      bread(32'h10, 32'h0, "R3 half extends");

      // R5 version
      select(8'h01);
      bwrite(32'h10, 32'hFFFF_FFFF, 2'd2);
      bread(32'h10, 32'h0017_0011, "R5 version");

      // R7 out of range
      select(8'h40);
      bwrite(32'h10, 32'h0, 2'd2);
      check("R7 no mask evt", {63'h0, mask_evt}, 64'h0);
      check("R7 mask kept", {40'h0, tbl_mask}, {40'h0, {NP{1'b1}}});
      bread(32'h10, 32'hFFFF_FFFF, "R7 ones");
      select(8'h05);
      bread(32'h10, 32'hFFFF_FFFF, "R7 gap");

      // R3 byte write into entry 0
      select(8'h10);
      bwrite(32'h10, 32'hFFFF_FF2A, 2'd0);
      check("R9 pin0 evt", {63'h0, mask_evt}, 64'h1);
      check("R9 pin0 num", {59'h0, mask_evt_pin}, 64'h0);
      bread(32'h10, 32'h0000_002A, "R3 byte");

      // R6 entry 5
      select(8'h1B);
      bwrite(32'h10, 32'hC300_0000, 2'd2);
      check("R6 dest", {56'h0, tbl_dest[8*5 +: 8]}, 64'hC3);
      check("R10 no svc", {63'h0, svc_evt}, 64'h0);
      select(8'h1A);
      bwrite(32'h10, 32'h0000_A531, 2'd2);
      check("R9 evt", {63'h0, mask_evt}, 64'h1);
      check("R9 pin", {59'h0, mask_evt_pin}, 64'd5);
      check("R9 val", {63'h0, mask_evt_val}, 64'h0);
      check("R6 vector", {56'h0, tbl_vector[8*5 +: 8]}, 64'h31);
      check("R6 dmode", {61'h0, tbl_dmode[3*5 +: 3]}, 64'h5);
      check("R6 level", {63'h0, tbl_level[5]}, 64'h1);
      bread(32'h10, 32'h0000_A531, "R6 lo read");
      select(8'h1B);
      bread(32'h10, 32'hC300_0000, "R6 hi read");

      // R10 with request on pin 5 via high-half write
      pin_level[5] = 1'b1;
      bwrite(32'h10, 32'h4400_0000, 2'd2);
      check("R10 hi svc", {63'h0, svc_evt}, 64'h1);
      check("R10 hi pin", {59'h0, svc_evt_pin}, 64'd5);

      // R10/R9 pin 7: masked level, then unmask -> both pulses
      pin_level[7] = 1'b1;
      select(8'h1E);
      bwrite(32'h10, 32'h0001_8040, 2'd2);
      check("R9 no change", {63'h0, mask_evt}, 64'h0);
      check("R10 svc", {63'h0, svc_evt}, 64'h1);
      check("R10 pin", {59'h0, svc_evt_pin}, 64'd7);
      bwrite(32'h10, 32'h0000_8041, 2'd2);
      check("R9 both evt", {63'h0, mask_evt}, 64'h1);
      check("R10 both svc", {63'h0, svc_evt}, 64'h1);
      check("R9 both pin", {59'h0, mask_evt_pin}, 64'd7);
      check("R10 both pin", {59'h0, svc_evt_pin}, 64'd7);

      // R8 remote-acknowledge
      @(negedge clk); rirr_set[7] = 1'b1;
      @(negedge clk); rirr_set[7] = 1'b0;
      check("R8 set", {63'h0, tbl_rirr[7]}, 64'h1);
      bread(32'h10, 32'h0000_C041, "R8 read set");
      select(8'h1F);
      bwrite(32'h10, 32'h0100_0000, 2'd2);
      check("R8 hi keeps", {63'h0, tbl_rirr[7]}, 64'h1);
      select(8'h1E);
      bwrite(32'h10, 32'h0000_4041, 2'd2);
      check("R8 lo clears", {63'h0, tbl_rirr[7]}, 64'h0);
      check("R10 edge no svc", {63'h0, svc_evt}, 64'h0);
      bread(32'h10, 32'h0000_0041, "R8 read cleared");

      // R12 hold
      repeat (3) @(negedge clk);
      check("R12 hold", {32'h0, bus_rdata}, 64'h0000_0041);

      repeat (3) @(negedge clk);
      check("scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule